// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing for a raster display. It runs on the pixel clock. A position counter walks each line, and a row counter walks each frame. From the two counts it derives the active-video window and the two sync pulses. It presents the current pixel column and row, together with an active-video flag, to a framebuffer reader.

Eight writable length registers set the timing, four for each axis. For each axis they hold the active length, the front porch, the sync width and the back porch. A ninth register sets the polarity of each sync pin. Every register reads back at the address it is written. Software writes a whole new timing set at any moment. The counters pick it up only where one frame ends and the next begins, so a half-written setting never reaches the display.

The sync pins pass through a short matching delay, so that they stay aligned with pixel words that come back from synchronous memory some cycles after the address went out. A separate, undelayed vertical-sync status bit lets a processor poll for the blanking interval before it issues drawing work.

Top module: `raster_timing_gen`

## Requirements
- R1: Register map. Horizontal lengths sit at addresses 0 (active), 1 (front porch), 2 (sync), 3 (back porch). Vertical lengths sit at addresses 4 to 7 in the same order. Address 8 is the configuration register: bit 0 selects the horizontal pin polarity and bit 1 selects the vertical pin polarity. A read returns the value last written to that address, with immediate effect. Any other address reads as zero.
- R2: `pix_x` counts 0, 1, ... up to the horizontal total minus 1 and then returns to 0. The horizontal total is the sum of the four horizontal lengths.
- R3: `pix_y` advances by one each time `pix_x` wraps. It returns to 0 after the row equal to the vertical total minus 1, and it holds its value at every other cycle.
- R4: `pix_active` is high exactly when `pix_x` is below the horizontal active length and `pix_y` is below the vertical active length.
- R5: An axis is in its sync region when its count is at least active+front and below active+front+sync.
- R6: `hsync_o` and `vsync_o` show the sync level of the position that was on `pix_x`/`pix_y` SYNC_DLY (default 2) cycles earlier. During the first SYNC_DLY cycles after reset they show the idle level.
- R7: A polarity bit of 1 makes that sync pin high inside its sync region and low outside it. A polarity bit of 0 inverts the pin. Both bits reset to 0.
- R8: `vsync_stat` is high exactly while `pix_y` is in the vertical sync region. It is not delayed and it does not depend on polarity.
- R9: Written lengths and polarity bits reach the counters and pins only from the cycle in which both counters restart at (0,0). Until then the previous set stays in use.
- R10: During reset both counters are zero, every register takes its parameter default, and the sync pins sit at their idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Read-back data for reg_addr (combinational) |
| pix_x | output | 12 | Current pixel column |
| pix_y | output | 12 | Current row |
| pix_active | output | 1 | Position lies in the visible window |
| hsync_o | output | 1 | Delayed horizontal sync pin |
| vsync_o | output | 1 | Delayed vertical sync pin |
| vsync_stat | output | 1 | Undelayed vertical-sync status for polling |

## Verification
A wrong counter state shows up on `pix_x` or `pix_y` in the very cycle it occurs. It also shows up on the sync pins two cycles later, and it persists for the rest of the frame because nothing resynchronises the counters before the frame wraps. A shadow set loaded at the wrong moment changes the line length or the active width within one line of the write, rather than after the next frame boundary. Checking positions on both sides of that boundary therefore catches it. A fault in the delay line or in the polarity handling appears as a pin edge one cycle early or late, or as an inverted pin, at the first sync region after the change.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int unsigned RT_CNT_W  = 12;
  localparam int unsigned RT_SUM_W  = RT_CNT_W + 2;
  localparam int unsigned RT_ADDR_W = 4;

  localparam logic [RT_ADDR_W-1:0] RA_H_ACT = 4'd0;
  localparam logic [RT_ADDR_W-1:0] RA_H_FP  = 4'd1;
  localparam logic [RT_ADDR_W-1:0] RA_H_SW  = 4'd2;
  localparam logic [RT_ADDR_W-1:0] RA_H_BP  = 4'd3;
  localparam logic [RT_ADDR_W-1:0] RA_V_ACT = 4'd4;
  localparam logic [RT_ADDR_W-1:0] RA_V_FP  = 4'd5;
  localparam logic [RT_ADDR_W-1:0] RA_V_SW  = 4'd6;
  localparam logic [RT_ADDR_W-1:0] RA_V_BP  = 4'd7;
  localparam logic [RT_ADDR_W-1:0] RA_CFG   = 4'd8;

  typedef logic [RT_CNT_W-1:0] rt_len_t;

  typedef struct packed {
    rt_len_t act;
    rt_len_t front;
    rt_len_t sync;
    rt_len_t back;
  } rt_axis_t;

  typedef struct packed {
    rt_axis_t h;
    rt_axis_t v;
    logic     hpol;
    logic     vpol;
  } rt_cfg_t;
endpackage

// File: rtl/rt_regfile.sv
module rt_regfile
  import rt_pkg::*;
#(
  parameter rt_cfg_t RST_CFG = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [RT_ADDR_W-1:0] addr,
  input  logic [RT_CNT_W-1:0]  wdata,
  input  logic                 frame_end,
  output logic [RT_CNT_W-1:0]  rdata,
  output rt_cfg_t              shad
);
  rt_cfg_t live_q, live_d, shad_q;
  logic    shad_en;

  always_comb begin
    live_d = live_q;
    case (addr)
      RA_H_ACT: live_d.h.act   = wdata;
      RA_H_FP:  live_d.h.front = wdata;
      RA_H_SW:  live_d.h.sync  = wdata;
      RA_H_BP:  live_d.h.back  = wdata;
      RA_V_ACT: live_d.v.act   = wdata;
      RA_V_FP:  live_d.v.front = wdata;
      RA_V_SW:  live_d.v.sync  = wdata;
      RA_V_BP:  live_d.v.back  = wdata;
      RA_CFG: begin
        live_d.hpol = wdata[0];
        live_d.vpol = wdata[1];
      end
      default: ;
    endcase
  end

  // shadow copy follows the live set only at the frame boundary
  assign shad_en = frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= RST_CFG;
    end else if (we) begin
      live_q <= live_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shad_q <= RST_CFG;
    end else if (shad_en) begin
      shad_q <= live_q;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_H_ACT: rdata = live_q.h.act;
      RA_H_FP:  rdata = live_q.h.front;
      RA_H_SW:  rdata = live_q.h.sync;
      RA_H_BP:  rdata = live_q.h.back;
      RA_V_ACT: rdata = live_q.v.act;
      RA_V_FP:  rdata = live_q.v.front;
      RA_V_SW:  rdata = live_q.v.sync;
      RA_V_BP:  rdata = live_q.v.back;
      RA_CFG:   rdata = {{(RT_CNT_W-2){1'b0}}, live_q.vpol, live_q.hpol};
      default:  rdata = '0;
    endcase
  end

  assign shad = shad_q;
endmodule

// File: rtl/rt_axis_ctr.sv
module rt_axis_ctr
  import rt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  rt_axis_t            len,
  output logic [RT_CNT_W-1:0] pos,
  output logic                at_last,
  output logic                in_act,
  output logic                in_sync
);
  logic [RT_CNT_W-1:0] pos_q, pos_d;
  logic [RT_SUM_W-1:0] pos_e, sync_lo, sync_hi, total;

  assign pos_e   = RT_SUM_W'(pos_q);
  assign sync_lo = RT_SUM_W'(len.act) + RT_SUM_W'(len.front);
  assign sync_hi = sync_lo + RT_SUM_W'(len.sync);
  assign total   = sync_hi + RT_SUM_W'(len.back);
  assign at_last = (pos_e == total - 1'b1);

  always_comb begin
    pos_d = pos_q;
    if (at_last) pos_d = '0;
    else         pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (adv) begin
      pos_q <= pos_d;
    end
  end

  assign in_act  = (pos_e < RT_SUM_W'(len.act));
  assign in_sync = (pos_e >= sync_lo) && (pos_e < sync_hi);
  assign pos     = pos_q;
endmodule

// File: rtl/rt_sync_delay.sv
module rt_sync_delay #(
  parameter int unsigned       DEPTH   = 2,
  parameter int unsigned       WIDTH   = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      logic [WIDTH-1:0] stg [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic [WIDTH-1:0] stg_d;
        if (i == 0) begin : g_first
          assign stg_d = din;
        end else begin : g_next
          assign stg_d = stg[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg_d;
        end
      end
      assign dout = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rt_pkg::*;
#(
  parameter int unsigned H_ACT    = 1920,
  parameter int unsigned H_FRONT  = 205,
  parameter int unsigned H_SYNC   = 50,
  parameter int unsigned H_BACK   = 255,
  parameter int unsigned V_ACT    = 1080,
  parameter int unsigned V_FRONT  = 2,
  parameter int unsigned V_SYNC   = 55,
  parameter int unsigned V_BACK   = 2,
  parameter bit          HPOL_RST = 1'b0,
  parameter bit          VPOL_RST = 1'b0,
  parameter int unsigned SYNC_DLY = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [RT_ADDR_W-1:0] reg_addr,
  input  logic [RT_CNT_W-1:0]  reg_wdata,
  output logic [RT_CNT_W-1:0]  reg_rdata,
  output logic [RT_CNT_W-1:0]  pix_x,
  output logic [RT_CNT_W-1:0]  pix_y,
  output logic                 pix_active,
  output logic                 hsync_o,
  output logic                 vsync_o,
  output logic                 vsync_stat
);
  localparam rt_cfg_t RST_CFG = '{
    h: '{act: rt_len_t'(H_ACT), front: rt_len_t'(H_FRONT),
         sync: rt_len_t'(H_SYNC), back: rt_len_t'(H_BACK)},
    v: '{act: rt_len_t'(V_ACT), front: rt_len_t'(V_FRONT),
         sync: rt_len_t'(V_SYNC), back: rt_len_t'(V_BACK)},
    hpol: HPOL_RST,
    vpol: VPOL_RST
  };
  localparam logic [1:0] IDLE_LVL = {~VPOL_RST, ~HPOL_RST};

  rt_cfg_t    shad_cfg;
  logic       h_last, v_last, frame_end;
  logic       h_act, v_act, h_sync, v_sync;
  logic [1:0] lvl_now, lvl_dly;

  rt_regfile #(.RST_CFG(RST_CFG)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .frame_end(frame_end),
    .rdata(reg_rdata), .shad(shad_cfg)
  );

  rt_axis_ctr u_hctr (
    .clk(clk), .rst_n(rst_n), .adv(1'b1), .len(shad_cfg.h),
    .pos(pix_x), .at_last(h_last), .in_act(h_act), .in_sync(h_sync)
  );

  rt_axis_ctr u_vctr (
    .clk(clk), .rst_n(rst_n), .adv(h_last), .len(shad_cfg.v),
    .pos(pix_y), .at_last(v_last), .in_act(v_act), .in_sync(v_sync)
  );

  assign frame_end  = h_last & v_last;
  assign pix_active = h_act & v_act;
  assign vsync_stat = v_sync;
  assign lvl_now    = {v_sync ~^ shad_cfg.vpol, h_sync ~^ shad_cfg.hpol};

  rt_sync_delay #(.DEPTH(SYNC_DLY), .WIDTH(2), .RST_VAL(IDLE_LVL)) u_dly (
    .clk(clk), .rst_n(rst_n), .din(lvl_now), .dout(lvl_dly)
  );

  assign hsync_o = lvl_dly[0];
  assign vsync_o = lvl_dly[1];
endmodule

// File: rtl/rt_checker.sv
module rt_checker
  import rt_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [RT_CNT_W-1:0] pix_x,
  input logic [RT_CNT_W-1:0] pix_y,
  input logic                pix_active,
  input logic                vsync_stat,
  input logic                hsync_o,
  input logic                frame_end,
  input rt_cfg_t             shad
);
  logic [RT_SUM_W-1:0] x_e, y_e, htot, vtot, vs_lo, vs_hi, hs_lo, hs_hi;
  logic [RT_CNT_W-1:0] x_inc, y_inc;
  logic                x_last, y_last, hs_lvl;
  logic [1:0]          age;

  assign x_e    = RT_SUM_W'(pix_x);
  assign y_e    = RT_SUM_W'(pix_y);
  assign hs_lo  = RT_SUM_W'(shad.h.act) + RT_SUM_W'(shad.h.front);
  assign hs_hi  = hs_lo + RT_SUM_W'(shad.h.sync);
  assign htot   = hs_hi + RT_SUM_W'(shad.h.back);
  assign vs_lo  = RT_SUM_W'(shad.v.act) + RT_SUM_W'(shad.v.front);
  assign vs_hi  = vs_lo + RT_SUM_W'(shad.v.sync);
  assign vtot   = vs_hi + RT_SUM_W'(shad.v.back);
  assign x_last = (x_e + 1'b1 == htot);
  assign y_last = (y_e + 1'b1 == vtot);
  assign x_inc  = pix_x + 1'b1;
  assign y_inc  = pix_y + 1'b1;
  assign hs_lvl = ((x_e >= hs_lo) && (x_e < hs_hi)) ? shad.hpol : ~shad.hpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  p_xstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !x_last |=> pix_x == $past(x_inc));
  p_xwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    x_last |=> pix_x == '0);
  p_ystep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (x_last && !y_last) |=> pix_y == $past(y_inc));
  p_yhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !x_last |=> $stable(pix_y));
  p_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_active |-> (x_e < RT_SUM_W'(shad.h.act)) && (y_e < RT_SUM_W'(shad.v.act)));
  p_vstat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_stat |-> (y_e >= vs_lo) && (y_e < vs_hi));
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(shad));
  p_hdelay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> hsync_o == $past(hs_lvl, 2));
endmodule

bind raster_timing_gen rt_checker u_rt_chk (
  .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
  .pix_active(pix_active), .vsync_stat(vsync_stat), .hsync_o(hsync_o),
  .frame_end(frame_end), .shad(shad_cfg)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
  localparam time CLK_P = 10ns;

  logic        clk, rst_n, reg_we;
  logic [3:0]  reg_addr;
  logic [11:0] reg_wdata, reg_rdata, pix_x, pix_y;
  logic        pix_active, hsync_o, vsync_o, vsync_stat;
  int          cyc, n_chk, n_fail;

  // H 6/2/3/1 -> 12 per line, V 4/1/2/1 -> 8 lines, 96 cycles per frame
  raster_timing_gen #(
    .H_ACT(6), .H_FRONT(2), .H_SYNC(3), .H_BACK(1),
    .V_ACT(4), .V_FRONT(1), .V_SYNC(2), .V_BACK(1), .SYNC_DLY(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_x(pix_x),
    .pix_y(pix_y), .pix_active(pix_active), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .vsync_stat(vsync_stat)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  // entry: {cycle[15:0], x[3:0], y[3:0], 4'b0, active, hsync, vsync, vstat}
  localparam logic [31:0] VEC [12] = '{
    {16'd0,  4'd0,  4'd0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'd3,  4'd3,  4'd0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'd10, 4'd10, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'd11, 4'd11, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'd12, 4'd0,  4'd1, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0},
    {16'd13, 4'd1,  4'd1, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'd49, 4'd1,  4'd4, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    {16'd61, 4'd1,  4'd5, 4'd0, 1'b0, 1'b1, 1'b1, 1'b1},
    {16'd62, 4'd2,  4'd5, 4'd0, 1'b0, 1'b1, 1'b0, 1'b1},
    {16'd85, 4'd1,  4'd7, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'd86, 4'd2,  4'd7, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    {16'd96, 4'd0,  4'd0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic wait_to(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input int exp, input string req);
    reg_addr = a;
    #1;
    chk(req, int'(reg_rdata), exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    // R10 reset state and R1 default read-back
    chk("R10 x", int'(pix_x), 0);
    chk("R10 y", int'(pix_y), 0);
    chk("R10 hsync idle", int'(hsync_o), 1);
    chk("R10 vsync idle", int'(vsync_o), 1);
    rd(4'd0, 6, "R10 h_act default");
    rd(4'd5, 1, "R10 v_front default");
    rd(4'd8, 0, "R7 polarity default");
    rd(4'd12, 0, "R1 unmapped address");
    reg_addr = '0;
    rst_n = 1'b1;

    // table walk: R2 x, R3 y, R4 active, R5/R6 pins, R8 status
    for (int i = 0; i < 12; i++) begin
      wait_to(int'(VEC[i][31:16]));
      chk("R2 x", int'(pix_x), int'(VEC[i][15:12]));
      chk("R3 y", int'(pix_y), int'(VEC[i][11:8]));
      chk("R4 active", int'(pix_active), int'(VEC[i][3]));
      chk("R5 R6 hsync", int'(hsync_o), int'(VEC[i][2]));
      chk("R5 R6 vsync", int'(vsync_o), int'(VEC[i][1]));
      chk("R8 vstat", int'(vsync_stat), int'(VEC[i][0]));
    end

    // R9: shrink horizontal active to 5 mid-frame at cycle 96
    wr(4'd0, 12'd5);
    rd(4'd0, 5, "R1 read-back after write");
    wait_to(101);
    chk("R9 old active still used", int'(pix_active), 1);
    wait_to(197);
    chk("R9 new active at frame start", int'(pix_active), 0);
    chk("R9 x in new frame", int'(pix_x), 5);
    wait_to(203);
    chk("R9 R2 new line total wraps x", int'(pix_x), 0);
    chk("R9 R3 y after new wrap", int'(pix_y), 1);

    // R7/R9: switch both pins to active-high, deferred to cycle 280
    wait_to(204);
    wr(4'd8, 12'd3);
    rd(4'd8, 3, "R1 config read-back");
    wait_to(213);
    chk("R9 polarity not yet applied", int'(hsync_o), 0);
    wait_to(290);
    chk("R7 hsync high in sync", int'(hsync_o), 1);
    wait_to(293);
    chk("R7 hsync low when idle", int'(hsync_o), 0);
    wait_to(338);
    chk("R7 vsync high in sync", int'(vsync_o), 1);
    chk("R8 vstat polarity free", int'(vsync_stat), 1);

    // R10: reset in mid-frame restores defaults
    wait_to(345);
    rst_n = 1'b0;
    #1;
    chk("R10 x after reset", int'(pix_x), 0);
    chk("R10 y after reset", int'(pix_y), 0);
    chk("R10 hsync idle after reset", int'(hsync_o), 1);
    rd(4'd0, 6, "R10 h_act restored");
    rd(4'd8, 0, "R10 polarity restored");
    @(negedge clk);
    finish_run();
  end
endmodule